// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is an in-order, five-stage integer pipeline for a small 32-bit load/store instruction subset: register-register ALU operations, word load, word store and branch-if-equal. Every instruction passes through fetch, decode with register read, execute, memory access and writeback. Pipeline registers separate the stages. All control is decoded once in decode and travels with the instruction, so each later stage uses only the control bits it needs.

The core has one instruction port and one data port. Both ports read combinationally within the cycle. The data port is written at the clock edge that ends the memory stage. Hazard handling is not built into the core. An external hazard and forwarding unit drives a stall input, a flush input and two operand bypass selects. Every instruction writes the register file only in the fifth stage, R-type included, so the single write port never has two writers in one cycle. A taken branch redirects fetch when the branch leaves the memory stage. The three instructions fetched behind it are not cancelled by the core.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, the fetch address is RESET_PC (default 0). During reset, no data-memory write and no writeback is signalled, and all registers read as zero afterwards.
- R2: When there is no stall and no taken branch, the fetch address grows by 4 every cycle. The word on the instruction port is the instruction at that address.
- R3: An R-type instruction (opcode 0x00) computes from its function field: add 0x20, subtract 0x22, and 0x24, or 0x25, xor 0x26, signed set-less-than 0x2A. Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], immediate [15:0] and function [5:0].
- R4: An instruction fetched in cycle i, stall-free, presents its register write on the writeback port in cycle i+4. This holds for loads and for R-type alike.
- R5: A register written in a cycle is returned to a decode-stage read of that register in the same cycle.
- R6: A load (opcode 0x23) reads the word at rs + sign-extended immediate into rt. A store (opcode 0x2B) writes rt to that address, with the write enable shown in cycle i+3.
- R7: Branch-if-equal (opcode 0x04) compares rs and rt. When they are equal, the fetch address in cycle i+4 is PC+4 + (sign-extended immediate << 2). When they differ, fetch falls through. The instructions fetched in cycles i+1..i+3 are not cancelled.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: A stall cycle holds the fetch address and the fetch/decode register and sends a bubble into execute. The held instruction leaves decode after the stall ends.
- R10: A flush cycle discards the instruction in decode. It writes no register and no memory, and fetch keeps advancing.
- R11: Each bypass select picks the operand that execute uses, including store data: 00 the decode-stage register value, 10 the ALU result in the execute/memory register, 01 the writeback value.
- R12: The destination register is rd for R-type and rt for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, write at end of cycle |
| dmem_re | output | 1 | Load enable |
| dmem_rdata | input | 32 | Load data at dmem_addr |
| hz_stall | input | 1 | Hold fetch and decode, bubble into execute |
| hz_flush | input | 1 | Turn the decode-stage instruction into a bubble |
| fwd_a | input | 2 | Bypass select for the rs operand |
| fwd_b | input | 2 | Bypass select for the rt operand and store data |
| wb_we | output | 1 | Register-file write enable |
| wb_addr | output | 5 | Register-file write address |
| wb_data | output | 32 | Register-file write data |

## Verification
The hardest behaviour to reach is a back-to-back dependency that only a bypass can satisfy. A correct result must come from the execute/memory register on one operand and from the writeback value on the other, in the same cycle. The store-data path also has to take a bypassed value. The bench reaches this with short programs whose dependent instructions follow at distance one and two. It drives the bypass selects from a per-cycle schedule, derived from the fixed stage timing, so that the register file still holds stale zeros when the consumer decodes. A missing or mis-encoded bypass therefore gives a visibly wrong value.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int IMMW = 16;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [1:0] FWD_RF  = 2'b00;
    localparam logic [1:0] FWD_WB  = 2'b01;
    localparam logic [1:0] FWD_MEM = 2'b10;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_fn_t;

    // control consumed by execute
    typedef struct packed {
        logic       reg_dst;
        logic [1:0] alu_op;
        logic       alu_src;
    } ex_ctl_t;

    // control consumed by memory access
    typedef struct packed {
        logic branch;
        logic mem_rd;
        logic mem_wr;
    } mem_ctl_t;

    // control consumed by writeback
    typedef struct packed {
        logic reg_wr;
        logic mem_to_reg;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        ctl_t            ctl;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] rs_val;
        logic [XLEN-1:0] rt_val;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [5:0]      funct;
    } idex_t;

    typedef struct packed {
        mem_ctl_t        mem;
        wb_ctl_t         wb;
        logic            zero;
        logic [XLEN-1:0] br_tgt;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] st_val;
        logic [RIDX-1:0] dst;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t         wb;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] ldata;
        logic [RIDX-1:0] dst;
    } memwb_t;

    function automatic ctl_t decode_op(input logic [5:0] op);
        ctl_t c;
        c = '0;
        case (op)
            OP_RTYPE: begin
                c.ex.reg_dst = 1'b1;
                c.ex.alu_op  = 2'b10;
                c.wb.reg_wr  = 1'b1;
            end
            OP_LOAD: begin
                c.ex.alu_src    = 1'b1;
                c.mem.mem_rd    = 1'b1;
                c.wb.reg_wr     = 1'b1;
                c.wb.mem_to_reg = 1'b1;
            end
            OP_STORE: begin
                c.ex.alu_src = 1'b1;
                c.mem.mem_wr = 1'b1;
            end
            OP_BEQ: begin
                c.ex.alu_op  = 2'b01;
                c.mem.branch = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic alu_fn_t select_fn(input logic [1:0] alu_op, input logic [5:0] funct);
        alu_fn_t f;
        f = ALU_ADD;
        if (alu_op == 2'b01) begin
            f = ALU_SUB;
        end else if (alu_op == 2'b10) begin
            case (funct)
                FN_SUB:  f = ALU_SUB;
                FN_AND:  f = ALU_AND;
                FN_OR:   f = ALU_OR;
                FN_XOR:  f = ALU_XOR;
                FN_SLT:  f = ALU_SLT;
                default: f = ALU_ADD;
            endcase
        end
        return f;
    endfunction

    function automatic logic [XLEN-1:0] fwd_pick(input logic [1:0] sel, input logic [XLEN-1:0] rf,
                                                 input logic [XLEN-1:0] mem, input logic [XLEN-1:0] wb);
        case (sel)
            FWD_MEM: return mem;
            FWD_WB:  return wb;
            default: return rf;
        endcase
    endfunction
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign q[g] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (rst)
                    q[g] <= '0;
                else if (we && wa == AW'(g))
                    q[g] <= wd;
            end
        end
    end

    // write-then-read within one cycle: a value being written is returned
    assign rd1 = (ra1 == '0) ? '0 : ((we && wa == ra1) ? wd : q[ra1]);
    assign rd2 = (ra2 == '0) ? '0 : ((we && wa == ra2) ? wd : q[ra2]);
endmodule

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctl_t            ctl,
    output logic [RIDX-1:0] rs,
    output logic [RIDX-1:0] rt,
    output logic [RIDX-1:0] rd,
    output logic [5:0]      funct,
    output logic [XLEN-1:0] imm
);
    assign ctl   = decode_op(instr[31:26]);
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign funct = instr[5:0];
    assign imm   = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_fn_t      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = W'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    output logic        dmem_re,
    input  logic [31:0] dmem_rdata,
    input  logic        hz_stall,
    input  logic        hz_flush,
    input  logic [1:0]  fwd_a,
    input  logic [1:0]  fwd_b,
    output logic        wb_we,
    output logic [4:0]  wb_addr,
    output logic [31:0] wb_data
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_plus4;
    ifid_t  ifid_q;
    idex_t  idex_q, idex_d;
    exmem_t exmem_q, exmem_d;
    memwb_t memwb_q, memwb_d;
    logic   br_take;

    // ---------------- fetch
    assign pc_plus4  = pc_q + STEP;
    assign imem_addr = pc_q;
    assign br_take   = exmem_q.mem.branch & exmem_q.zero;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (br_take)
            pc_q <= exmem_q.br_tgt;
        else if (!hz_stall)
            pc_q <= pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ifid_q <= '0;
        else if (!hz_stall || br_take)
            ifid_q <= '{pc4: pc_plus4, instr: imem_rdata};
    end

    // ---------------- decode
    ctl_t            id_ctl;
    logic [RIDX-1:0] id_rs, id_rt, id_rd;
    logic [5:0]      id_funct;
    logic [XLEN-1:0] id_imm, id_rs_val, id_rt_val, wb_val;

    pipe5_ctrl u_ctrl (
        .instr (ifid_q.instr),
        .ctl   (id_ctl),
        .rs    (id_rs),
        .rt    (id_rt),
        .rd    (id_rd),
        .funct (id_funct),
        .imm   (id_imm)
    );

    pipe5_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (id_rs),
        .ra2 (id_rt),
        .rd1 (id_rs_val),
        .rd2 (id_rt_val),
        .we  (memwb_q.wb.reg_wr),
        .wa  (memwb_q.dst),
        .wd  (wb_val)
    );

    always_comb begin
        idex_d.ctl    = (hz_stall || hz_flush) ? ctl_t'('0) : id_ctl;
        idex_d.pc4    = ifid_q.pc4;
        idex_d.rs_val = id_rs_val;
        idex_d.rt_val = id_rt_val;
        idex_d.imm    = id_imm;
        idex_d.rt     = id_rt;
        idex_d.rd     = id_rd;
        idex_d.funct  = id_funct;
    end

    always_ff @(posedge clk) begin
        if (rst)
            idex_q <= '0;
        else
            idex_q <= idex_d;
    end

    // ---------------- execute
    logic [XLEN-1:0] opa, opb_reg, opb, alu_y;
    logic            alu_zero;

    assign opa     = fwd_pick(fwd_a, idex_q.rs_val, exmem_q.alu, wb_val);
    assign opb_reg = fwd_pick(fwd_b, idex_q.rt_val, exmem_q.alu, wb_val);
    assign opb     = idex_q.ctl.ex.alu_src ? idex_q.imm : opb_reg;

    pipe5_alu #(.W(XLEN)) u_alu (
        .fn   (select_fn(idex_q.ctl.ex.alu_op, idex_q.funct)),
        .a    (opa),
        .b    (opb),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        exmem_d.mem    = idex_q.ctl.mem;
        exmem_d.wb     = idex_q.ctl.wb;
        exmem_d.zero   = alu_zero;
        exmem_d.br_tgt = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
        exmem_d.alu    = alu_y;
        exmem_d.st_val = opb_reg;
        exmem_d.dst    = idex_q.ctl.ex.reg_dst ? idex_q.rd : idex_q.rt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            exmem_q <= '0;
        else
            exmem_q <= exmem_d;
    end

    // ---------------- memory access
    assign dmem_addr  = exmem_q.alu;
    assign dmem_wdata = exmem_q.st_val;
    assign dmem_we    = exmem_q.mem.mem_wr;
    assign dmem_re    = exmem_q.mem.mem_rd;

    always_comb begin
        memwb_d.wb    = exmem_q.wb;
        memwb_d.alu   = exmem_q.alu;
        memwb_d.ldata = dmem_rdata;
        memwb_d.dst   = exmem_q.dst;
    end

    always_ff @(posedge clk) begin
        if (rst)
            memwb_q <= '0;
        else
            memwb_q <= memwb_d;
    end

    // ---------------- writeback
    assign wb_val  = memwb_q.wb.mem_to_reg ? memwb_q.ldata : memwb_q.alu;
    assign wb_we   = memwb_q.wb.reg_wr;
    assign wb_addr = memwb_q.dst;
    assign wb_data = wb_val;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic        dmem_we,
    input logic        dmem_re,
    input logic        wb_we,
    input logic        hz_stall,
    input logic        hz_flush,
    input logic        br_take
);
    a_r1_reset_pc: assert property (@(posedge clk)
        $past(rst) && !rst |-> imem_addr == RESET_PC);

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (!hz_stall && !br_take) |=> imem_addr == $past(imem_addr) + 32'd4);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (hz_stall && !br_take) |=> $stable(imem_addr));

    a_r10_bubble_no_write: assert property (@(posedge clk) disable iff (rst)
        (hz_flush || hz_stall) |=> ##2 !wb_we);

    a_r6_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));
endmodule

bind pipe5_core pipe5_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re),
    .wb_we     (wb_we),
    .hz_stall  (hz_stall),
    .hz_flush  (hz_flush),
    .br_take   (br_take)
);

// File: tb/sim_pipe5_core.sv
`timescale 1ns/1ps
module sim_pipe5_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
    logic        dmem_we, dmem_re, wb_we;
    logic        hz_stall = 1'b0, hz_flush = 1'b0;
    logic [1:0]  fwd_a = 2'b00, fwd_b = 2'b00;
    logic [4:0]  wb_addr;

    logic [31:0] imem [64];
    logic [31:0] dmem [16];
    logic        st_s [64];
    logic        fl_s [64];
    logic [1:0]  fa_s [64];
    logic [1:0]  fb_s [64];
    logic [31:0] pcs  [64];
    logic        wbv  [64];
    logic [31:0] wval [32];
    int          wcnt [32];
    int          wcyc [32];
    int          st_cyc;
    logic [31:0] st_addr;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];

    pipe5_core u0 (
        .clk (clk), .rst (rst),
        .imem_addr (imem_addr), .imem_rdata (imem_rdata),
        .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata),
        .dmem_we (dmem_we), .dmem_re (dmem_re), .dmem_rdata (dmem_rdata),
        .hz_stall (hz_stall), .hz_flush (hz_flush),
        .fwd_a (fwd_a), .fwd_b (fwd_b),
        .wb_we (wb_we), .wb_addr (wb_addr), .wb_data (wb_data)
    );

    function automatic logic [31:0] r_op(input logic [5:0] fn, input logic [4:0] rd, rs, rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] i_op(input logic [5:0] op, input logic [4:0] rt, rs, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0; st_s[i] = 1'b0; fl_s[i] = 1'b0; fa_s[i] = 2'b00; fb_s[i] = 2'b00;
        end
        for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
        dmem[0] = 32'd100;       dmem[1] = 32'hFFFF_FFF9;
        dmem[3] = 32'hCAFE_0001; dmem[4] = 32'd16;
        dmem[5] = 32'h55;        dmem[7] = 32'h77;
        imem[0] = i_op(6'h23, 5'd1, 5'd0, 16'd0);
        imem[1] = i_op(6'h23, 5'd2, 5'd0, 16'd4);
    endtask

    task automatic run_prog(input int ncyc);
        logic        we_s;
        logic [31:0] a_s, d_s;
        for (int r = 0; r < 32; r++) begin wval[r] = '0; wcnt[r] = 0; wcyc[r] = -1; end
        st_cyc = -1; st_addr = '0;
        rst = 1'b1; hz_stall = 1'b0; hz_flush = 1'b0; fwd_a = 2'b00; fwd_b = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            pcs[c] = imem_addr;
            wbv[c] = wb_we;
            if (wb_we && wb_addr != 5'd0) begin
                wval[wb_addr] = wb_data; wcnt[wb_addr]++; wcyc[wb_addr] = c;
            end
            we_s = dmem_we; a_s = dmem_addr; d_s = dmem_wdata;
            if (dmem_we && st_cyc < 0) begin st_cyc = c; st_addr = dmem_addr; end
            hz_stall = st_s[c]; hz_flush = fl_s[c]; fwd_a = fa_s[c]; fwd_b = fb_s[c];
            @(posedge clk);
            if (we_s) dmem[a_s[5:2]] = d_s;
            @(negedge clk);
        end
        hz_stall = 1'b0; hz_flush = 1'b0; fwd_a = 2'b00; fwd_b = 2'b00;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", imem_addr, 32'h0);
        chk("R1 reset no store", {31'd0, dmem_we}, 32'd0);
        chk("R1 reset no writeback", {31'd0, wb_we}, 32'd0);
    endtask

    task automatic t_alu_mem();
        int bad;
        clear_prog();
        imem[4]  = r_op(6'h20, 5'd3, 5'd1, 5'd2);
        imem[5]  = r_op(6'h22, 5'd4, 5'd1, 5'd2);
        imem[6]  = r_op(6'h24, 5'd5, 5'd1, 5'd2);
        imem[7]  = r_op(6'h25, 5'd6, 5'd1, 5'd2);
        imem[8]  = r_op(6'h26, 5'd7, 5'd1, 5'd2);
        imem[9]  = r_op(6'h2A, 5'd8, 5'd1, 5'd2);
        imem[10] = r_op(6'h2A, 5'd9, 5'd2, 5'd1);
        imem[11] = r_op(6'h20, 5'd0, 5'd1, 5'd2);
        imem[12] = i_op(6'h23, 5'd13, 5'd0, 16'd16);
        imem[16] = i_op(6'h23, 5'd10, 5'd13, 16'hFFFC);
        imem[17] = i_op(6'h2B, 5'd3, 5'd0, 16'd8);
        imem[18] = i_op(6'h2B, 5'd0, 5'd0, 16'd20);
        run_prog(28);
        bad = 0;
        for (int c = 0; c < 10; c++) if (pcs[c] !== 32'(4 * c)) bad++;
        chk("R2 sequential fetch mismatches", 32'(bad), 32'd0);
        chk("R5 same-cycle write visible (add)", wval[3], 32'd93);
        chk("R3 sub", wval[4], 32'd107);
        chk("R3 and", wval[5], 32'h60);
        chk("R3 or", wval[6], 32'hFFFF_FFFD);
        chk("R3 xor", wval[7], 32'hFFFF_FF9D);
        chk("R3 slt false", wval[8], 32'd0);
        chk("R3 slt true", wval[9], 32'd1);
        chk("R4 load writeback cycle", 32'(wcyc[1]), 32'd4);
        chk("R4 rtype writeback cycle", 32'(wcyc[3]), 32'd8);
        chk("R12 rtype dest rd not rt", 32'(wcnt[2]), 32'd1);
        chk("R12 load dest rt", wval[13], 32'd16);
        chk("R6 load negative offset", wval[10], 32'hCAFE_0001);
        chk("R6 store cycle", 32'(st_cyc), 32'd20);
        chk("R6 store address", st_addr, 32'd8);
        chk("R6 store data", dmem[2], 32'd93);
        chk("R8 r0 reads zero after write", dmem[5], 32'd0);
    endtask

    task automatic t_branch();
        clear_prog();
        imem[4]  = i_op(6'h04, 5'd1, 5'd1, 16'd5);
        imem[8]  = r_op(6'h20, 5'd20, 5'd1, 5'd1);
        imem[9]  = r_op(6'h20, 5'd21, 5'd1, 5'd1);
        imem[10] = r_op(6'h20, 5'd22, 5'd1, 5'd1);
        imem[11] = i_op(6'h04, 5'd2, 5'd1, 16'd5);
        imem[15] = r_op(6'h20, 5'd23, 5'd1, 5'd2);
        run_prog(26);
        chk("R7 taken redirect pc", pcs[8], 32'd40);
        chk("R7 skipped instr not written", 32'(wcnt[20] + wcnt[21]), 32'd0);
        chk("R7 target instr result", wval[22], 32'd200);
        chk("R7 not-taken falls through", wval[23], 32'd93);
    endtask

    task automatic t_forward();
        clear_prog();
        imem[4]  = r_op(6'h20, 5'd3, 5'd1, 5'd2);
        imem[5]  = r_op(6'h22, 5'd4, 5'd3, 5'd1);
        imem[6]  = r_op(6'h25, 5'd5, 5'd3, 5'd4);
        imem[7]  = i_op(6'h2B, 5'd5, 5'd0, 16'd24);
        imem[8]  = i_op(6'h23, 5'd6, 5'd0, 16'd0);
        imem[10] = r_op(6'h20, 5'd7, 5'd6, 5'd6);
        fa_s[7]  = 2'b10;
        fa_s[8]  = 2'b01; fb_s[8] = 2'b10;
        fb_s[9]  = 2'b10;
        fa_s[12] = 2'b01; fb_s[12] = 2'b01;
        run_prog(22);
        chk("R11 bypass from exec/mem", wval[4], 32'hFFFF_FFF9);
        chk("R11 bypass wb on a, exec/mem on b", wval[5], 32'hFFFF_FFFD);
        chk("R11 bypass store data", dmem[6], 32'hFFFF_FFFD);
        chk("R11 bypass load result", wval[7], 32'd200);
    endtask

    task automatic t_stall();
        clear_prog();
        imem[4] = r_op(6'h20, 5'd3, 5'd1, 5'd2);
        imem[5] = r_op(6'h22, 5'd4, 5'd1, 5'd2);
        imem[6] = r_op(6'h24, 5'd5, 5'd1, 5'd2);
        st_s[6] = 1'b1; st_s[7] = 1'b1;
        run_prog(20);
        chk("R9 pc held cycle 7", pcs[7], 32'd24);
        chk("R9 pc held cycle 8", pcs[8], 32'd24);
        chk("R9 pc resumes", pcs[9], 32'd28);
        chk("R9 older instr unaffected", 32'(wcyc[3]), 32'd8);
        chk("R9 held instr delayed", 32'(wcyc[4]), 32'd11);
        chk("R9 next instr delayed", 32'(wcyc[5]), 32'd12);
        chk("R9 bubbles write nothing", {31'd0, wbv[9] | wbv[10]}, 32'd0);
        chk("R9 held instr once", 32'(wcnt[4]), 32'd1);
        chk("R9 held instr value", wval[4], 32'd107);
    endtask

    task automatic t_flush();
        clear_prog();
        imem[4] = r_op(6'h20, 5'd3, 5'd1, 5'd2);
        imem[5] = r_op(6'h22, 5'd4, 5'd1, 5'd2);
        imem[6] = r_op(6'h24, 5'd5, 5'd1, 5'd2);
        imem[7] = i_op(6'h2B, 5'd1, 5'd0, 16'd28);
        fl_s[6] = 1'b1; fl_s[8] = 1'b1;
        run_prog(20);
        chk("R10 flushed instr not written", 32'(wcnt[4]), 32'd0);
        chk("R10 flushed store no effect", dmem[7], 32'h77);
        chk("R10 fetch not held", pcs[7], 32'd28);
        chk("R10 following instr timing", 32'(wcyc[5]), 32'd10);
        chk("R10 following instr value", wval[5], 32'h60);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-R12 run: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_alu_mem();
        t_branch();
        t_forward();
        t_stall();
        t_flush();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule